// File: doc/BRIEF.md
# Single-Channel DMA Transfer Sequencer

This block is one DMA channel. A single configuration write loads a control byte, a source address, a destination address and a unit count. The same write may also enable the channel. The control byte selects four things: the unit size, where transfer requests come from, how the acknowledge strobe is placed, and which address mode is used. Once the write is accepted, the channel moves units over a simple synchronous memory bus. Each bus cycle lasts one clock, and reads and writes are separate cycles. After every unit the channel counts down. When the last unit completes, it drops busy and emits a one-cycle done pulse.

In dual address mode each beat is a read cycle at the source followed by a write cycle at the destination. In single address mode each beat is one cycle between memory and a device, and the device is strobed by the acknowledge output. The 16-byte unit is carried out as four back-to-back longword beats. Illegal settings are rejected when the configuration is written: either a configuration-error flag or an address-error flag is raised, and the channel never starts.

Two low-power inputs are provided:
- Full standby clears the control fields and stops the channel.
- Module standby keeps every field but holds off new units.

Top module: `dma_seq`

## Requirements
- R1: After reset `cfg_o` reads 0, and `busy_o`, `done_o`, `cfg_err_o` and `addr_err_o` are all low.
- R2: The control byte on `cfg_ctrl_i` is laid out as follows: [1:0] size (00 byte, 01 word, 10 longword, 11 16-byte), [2] auto-request, [3] mode bit, [4] level detect, [5] peripheral source, [6] single address mode, [7] destination is internal memory. With bit 2 set, units run back to back without any request input.
- R3: In dual address mode each beat is a read cycle at the source. It is followed in the next clock by a write cycle at the destination, whose `bus_wdata_o` equals the data returned by that read.
- R4: In dual address mode `dack_o` is high in the read cycle when the mode bit is 0, and in the write cycle when the mode bit is 1, never in the other cycle.
- R5: In single address mode each beat is a single cycle with `dack_o` high. With the mode bit at 0 it is a read at the source address (memory to device). With the mode bit at 1 it is a write at the destination address (device to memory).
- R6: `bus_size_o` carries the size code, and both addresses step by 1, 2 or 4 per unit. A 16-byte unit is four longword beats (`bus_size_o` = 10) in consecutive clocks, stepping by 4 per beat and by 16 per unit.
- R7: The count drops by one per unit. After the last unit `busy_o` is low and `done_o` is high for exactly one cycle.
- R8: In edge mode (bits 2, 4 and 5 all 0), one unit runs per rising edge of `ext_req_i`, and no bus cycle occurs while no edge is pending.
- R9: In level mode (bit 4 set) units run while `ext_req_i` is high. In peripheral mode (bit 5 set) units run while `per_req_i` is high.
- R10: An enabling write raises `cfg_err_o` and does not start the channel when any of these holds: the count is zero; the size is 16-byte with bit 2 at 0 and bit 4 or bit 5 set; or the size is byte in dual address mode with bit 7 set. Single address mode with bit 7 set is legal.
- R11: An enabling write with longword size and a source or destination not 4-aligned, or with 16-byte size and an address not 16-aligned, raises `addr_err_o` and does not start the channel. Byte and word units accept any address.
- R12: A cycle of `stby_i` clears `cfg_o` to 0 and stops the channel. While `mstby_i` is high, `cfg_o` and `busy_o` hold and no new unit starts. Once `mstby_i` is released, the pending transfer runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| stby_i | input | 1 | Full standby: clear control fields, stop channel |
| mstby_i | input | 1 | Module standby: hold fields, start no new unit |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_en_i | input | 1 | Enable channel with this write |
| cfg_ctrl_i | input | 8 | Control byte (layout in R2) |
| cfg_src_i | input | AW | Source start address |
| cfg_dst_i | input | AW | Destination start address |
| cfg_cnt_i | input | CW | Unit count |
| ext_req_i | input | 1 | External request (asynchronous) |
| per_req_i | input | 1 | Peripheral request level (asynchronous) |
| bus_rd_o | output | 1 | Read cycle |
| bus_wr_o | output | 1 | Write cycle |
| bus_addr_o | output | AW | Bus address |
| bus_size_o | output | 2 | Beat size code |
| bus_wdata_o | output | DW | Write data (dual address mode) |
| bus_rdata_i | input | DW | Read data, valid in the read cycle |
| dack_o | output | 1 | Acknowledge strobe |
| busy_o | output | 1 | Channel enabled |
| done_o | output | 1 | One-cycle pulse after the last unit |
| cfg_o | output | 8 | Control byte readback |
| cfg_err_o | output | 1 | Configuration rejected |
| addr_err_o | output | 1 | Misaligned start address rejected |

## Verification
The main function is tried with four kinds of request pattern:
- Auto-request shows back-to-back unit issue.
- Pulsed edges separate per-edge servicing from free running, because the bench requires silence between pulses.
- Held levels on the external and on the peripheral input show which input is selected.

Each pattern is combined with every size and both address modes. The byte and word cases use unaligned offsets, and the 16-byte cases expose the four-beat split and the stride. Flipping the mode bit shows the two meanings of that bit: in dual address mode the acknowledge moves between the read and write cycles, and in single address mode the cycle type and the address used change. The illegal combinations are each paired with a legal neighbour that differs in one field, so that a rejection cannot come from a broader rule than the requirement states.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;
  typedef enum logic [1:0] {SZ_BYTE = 2'b00, SZ_WORD = 2'b01, SZ_LONG = 2'b10, SZ_16B = 2'b11} unit_e;
  typedef enum logic [1:0] {ST_IDLE, ST_RD, ST_WR, ST_SGL} state_e;

  typedef struct packed {
    logic  dst_int;
    logic  single;
    logic  per_sel;
    logic  lvl;
    logic  am;
    logic  auto_req;
    unit_e size;
  } mode_t;

  // bytes moved by one bus beat; the 16-byte unit runs as longword beats
  function automatic logic [4:0] beat_bytes(unit_e s);
    case (s)
      SZ_BYTE: return 5'd1;
      SZ_WORD: return 5'd2;
      default: return 5'd4;
    endcase
  endfunction
endpackage

// File: rtl/dma_cfg_reg.sv
module dma_cfg_reg
  import dma_seq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       stby_i,
  input  logic       we_i,
  input  logic       en_i,
  input  mode_t      ctrl_i,
  input  logic [3:0] src_lo_i,
  input  logic [3:0] dst_lo_i,
  input  logic       cnt_zero_i,
  output mode_t      ctrl_o,
  output logic       start_o,
  output logic       cfg_err_o,
  output logic       addr_err_o
);
  mode_t      ctrl_q;
  logic       cfg_err_q, addr_err_q;
  logic       cerr, aerr;
  logic [3:0] amask;

  always_comb begin
    case (ctrl_i.size)
      SZ_16B:  amask = 4'hF;
      SZ_LONG: amask = 4'h3;
      default: amask = 4'h0;
    endcase
    aerr = |((src_lo_i | dst_lo_i) & amask);
    cerr = cnt_zero_i
         | ((ctrl_i.size == SZ_16B) & ~ctrl_i.auto_req & (ctrl_i.lvl | ctrl_i.per_sel))
         | (~ctrl_i.single & (ctrl_i.size == SZ_BYTE) & ctrl_i.dst_int);
  end

  assign start_o = we_i & en_i & ~stby_i & ~cerr & ~aerr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q     <= '0;
      cfg_err_q  <= 1'b0;
      addr_err_q <= 1'b0;
    end else if (stby_i) begin
      ctrl_q     <= '0;
      cfg_err_q  <= 1'b0;
      addr_err_q <= 1'b0;
    end else if (we_i) begin
      ctrl_q     <= ctrl_i;
      cfg_err_q  <= en_i & cerr;
      addr_err_q <= en_i & aerr;
    end
  end

  assign ctrl_o     = ctrl_q;
  assign cfg_err_o  = cfg_err_q;
  assign addr_err_o = addr_err_q;

  // R12
  stby_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(stby_i) |-> (ctrl_q == '0));
  // R11
  aerr_nostart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_err_q |-> $past(!start_o));
endmodule

// File: rtl/dma_req_gate.sv
module dma_req_gate #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ext_req_i,
  input  logic per_req_i,
  input  logic auto_req_i,
  input  logic lvl_i,
  input  logic per_sel_i,
  input  logic take_i,
  input  logic clr_i,
  output logic req_o
);
  logic [SYNC_STAGES-1:0] ext_sync, per_sync;
  logic ext_prev, pend_q, rise;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ext_sync <= '0;
      per_sync <= '0;
      ext_prev <= 1'b0;
    end else begin
      ext_sync <= {ext_sync[SYNC_STAGES-2:0], ext_req_i};
      per_sync <= {per_sync[SYNC_STAGES-2:0], per_req_i};
      ext_prev <= ext_sync[SYNC_STAGES-1];
    end
  end

  assign rise = ext_sync[SYNC_STAGES-1] & ~ext_prev;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pend_q <= 1'b0;
    else if (clr_i)  pend_q <= 1'b0;
    else if (rise)   pend_q <= 1'b1;
    else if (take_i) pend_q <= 1'b0;
  end

  always_comb begin
    if (auto_req_i)     req_o = 1'b1;
    else if (per_sel_i) req_o = per_sync[SYNC_STAGES-1];
    else if (lvl_i)     req_o = ext_sync[SYNC_STAGES-1];
    else                req_o = pend_q;
  end

  // R8
  edge_once_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_i & ~rise & ~auto_req_i & ~lvl_i & ~per_sel_i) |=> !pend_q);
endmodule

// File: rtl/dma_seq.sv
module dma_seq
  import dma_seq_pkg::*;
#(
  parameter int AW          = 32,
  parameter int DW          = 32,
  parameter int CW          = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          stby_i,
  input  logic          mstby_i,
  input  logic          cfg_we_i,
  input  logic          cfg_en_i,
  input  logic [7:0]    cfg_ctrl_i,
  input  logic [AW-1:0] cfg_src_i,
  input  logic [AW-1:0] cfg_dst_i,
  input  logic [CW-1:0] cfg_cnt_i,
  input  logic          ext_req_i,
  input  logic          per_req_i,
  output logic          bus_rd_o,
  output logic          bus_wr_o,
  output logic [AW-1:0] bus_addr_o,
  output logic [1:0]    bus_size_o,
  output logic [DW-1:0] bus_wdata_o,
  input  logic [DW-1:0] bus_rdata_i,
  output logic          dack_o,
  output logic          busy_o,
  output logic          done_o,
  output logic [7:0]    cfg_o,
  output logic          cfg_err_o,
  output logic          addr_err_o
);
  localparam int LAST_BEAT = 3;

  mode_t   ctrl;
  state_e  state_q;
  logic    start, req, take, last_beat, en_q, done_q;
  logic [1:0]    beat_q;
  logic [AW-1:0] src_q, dst_q, step;
  logic [CW-1:0] cnt_q;
  logic [DW-1:0] data_q;

  dma_cfg_reg u_cfg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .stby_i     (stby_i),
    .we_i       (cfg_we_i),
    .en_i       (cfg_en_i),
    .ctrl_i     (mode_t'(cfg_ctrl_i)),
    .src_lo_i   (cfg_src_i[3:0]),
    .dst_lo_i   (cfg_dst_i[3:0]),
    .cnt_zero_i (cfg_cnt_i == '0),
    .ctrl_o     (ctrl),
    .start_o    (start),
    .cfg_err_o  (cfg_err_o),
    .addr_err_o (addr_err_o)
  );

  dma_req_gate #(.SYNC_STAGES(SYNC_STAGES)) u_req (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ext_req_i  (ext_req_i),
    .per_req_i  (per_req_i),
    .auto_req_i (ctrl.auto_req),
    .lvl_i      (ctrl.lvl),
    .per_sel_i  (ctrl.per_sel),
    .take_i     (take),
    .clr_i      (stby_i | cfg_we_i),
    .req_o      (req)
  );

  assign take      = (state_q == ST_IDLE) & en_q & req & ~mstby_i & ~start & ~stby_i;
  assign last_beat = (ctrl.size != SZ_16B) | (beat_q == 2'(LAST_BEAT));
  assign step      = AW'(beat_bytes(ctrl.size));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      beat_q  <= '0;
      src_q   <= '0;
      dst_q   <= '0;
      cnt_q   <= '0;
      data_q  <= '0;
      en_q    <= 1'b0;
      done_q  <= 1'b0;
    end else if (stby_i) begin
      state_q <= ST_IDLE;
      en_q    <= 1'b0;
      done_q  <= 1'b0;
    end else if (start) begin
      state_q <= ST_IDLE;
      beat_q  <= '0;
      src_q   <= cfg_src_i;
      dst_q   <= cfg_dst_i;
      cnt_q   <= cfg_cnt_i;
      en_q    <= 1'b1;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: if (take) begin
          state_q <= ctrl.single ? ST_SGL : ST_RD;
          beat_q  <= '0;
        end
        ST_RD: begin
          data_q  <= bus_rdata_i;
          state_q <= ST_WR;
        end
        default: begin
          src_q <= src_q + step;
          dst_q <= dst_q + step;
          if (!last_beat) begin
            beat_q  <= beat_q + 2'd1;
            state_q <= (state_q == ST_WR) ? ST_RD : ST_SGL;
          end else begin
            state_q <= ST_IDLE;
            cnt_q   <= cnt_q - CW'(1);
            if (cnt_q == CW'(1)) begin
              en_q   <= 1'b0;
              done_q <= 1'b1;
            end
          end
        end
      endcase
    end
  end

  always_comb begin
    bus_rd_o   = (state_q == ST_RD) | ((state_q == ST_SGL) & ~ctrl.am);
    bus_wr_o   = (state_q == ST_WR) | ((state_q == ST_SGL) & ctrl.am);
    bus_addr_o = bus_wr_o ? dst_q : src_q;
    bus_size_o = (ctrl.size == SZ_16B) ? SZ_LONG : ctrl.size;
    dack_o     = ((state_q == ST_RD) & ~ctrl.am) | ((state_q == ST_WR) & ctrl.am)
               | (state_q == ST_SGL);
  end

  assign bus_wdata_o = data_q;
  assign busy_o      = en_q;
  assign done_o      = done_q;
  assign cfg_o       = ctrl;

  // R3
  rd_then_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RD) & ~stby_i |=> bus_wr_o);
  // R3
  rw_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({bus_rd_o, bus_wr_o}));
  // R5
  dack_in_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dack_o |-> (bus_rd_o | bus_wr_o));
  // R7
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R7
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  // R10
  cfg_err_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_err_o |-> !busy_o);
  // R11
  align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_rd_o | bus_wr_o) & ctrl.size[1] |-> (bus_addr_o[1:0] == 2'b00));
endmodule

// File: tb/dma_seq_bench.sv
module dma_seq_bench;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        stby = 1'b0, mstby = 1'b0;
  logic        cfg_we = 1'b0, cfg_en = 1'b0;
  logic [7:0]  cfg_ctrl = '0;
  logic [31:0] cfg_src = '0, cfg_dst = '0;
  logic [15:0] cfg_cnt = '0;
  logic        ext_req = 1'b0, per_req = 1'b0;
  logic        bus_rd, bus_wr, dack, busy, done, cfg_err, addr_err;
  logic [31:0] bus_addr, bus_wdata, bus_rdata;
  logic [1:0]  bus_size;
  logic [7:0]  cfg_rb;
  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  function automatic logic [31:0] dfun(input logic [31:0] a);
    return (a * 32'h9E3779B1) ^ 32'h5A5AC3C3;
  endfunction
  assign bus_rdata = dfun(bus_addr);

  dma_seq u_dma_seq (
    .clk_i(clk), .rst_ni(rst_ni), .stby_i(stby), .mstby_i(mstby),
    .cfg_we_i(cfg_we), .cfg_en_i(cfg_en), .cfg_ctrl_i(cfg_ctrl),
    .cfg_src_i(cfg_src), .cfg_dst_i(cfg_dst), .cfg_cnt_i(cfg_cnt),
    .ext_req_i(ext_req), .per_req_i(per_req),
    .bus_rd_o(bus_rd), .bus_wr_o(bus_wr), .bus_addr_o(bus_addr),
    .bus_size_o(bus_size), .bus_wdata_o(bus_wdata), .bus_rdata_i(bus_rdata),
    .dack_o(dack), .busy_o(busy), .done_o(done), .cfg_o(cfg_rb),
    .cfg_err_o(cfg_err), .addr_err_o(addr_err)
  );

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s act=%0h exp=%0h", rq, what, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [7:0] c, input logic [31:0] s, input logic [31:0] d,
                           input logic [15:0] n, input logic en);
    @(negedge clk);
    cfg_we = 1'b1; cfg_en = en; cfg_ctrl = c; cfg_src = s; cfg_dst = d; cfg_cnt = n;
    @(negedge clk);
    cfg_we = 1'b0; cfg_en = 1'b0;
  endtask

  task automatic idle_window(input int cyc, input string rq);
    for (int i = 0; i < cyc; i++) begin
      @(negedge clk);
      chk(!(bus_rd | bus_wr), rq, "bus cycle while idle", {bus_rd, bus_wr}, 0);
    end
  endtask

  task automatic run_check(input logic [7:0] c, input logic [31:0] s0, input logic [31:0] d0,
                           input logic [15:0] n);
    logic [1:0] sz = c[1:0];
    logic am = c[3], single = c[6];
    logic is_edge = !c[2] && !c[4] && !c[5];
    int beats = (sz == 2'b11) ? 4 : 1;
    logic [31:0] stp = (sz == 2'b00) ? 1 : (sz == 2'b01) ? 2 : 4;
    logic [1:0] bsz = (sz == 2'b11) ? 2'b10 : sz;
    logic [31:0] s = s0, d = d0;
    string rq = c[2] ? "R2" : is_edge ? "R8" : "R9";
    if (!c[2] && !is_edge) begin
      if (c[5]) per_req = 1'b1; else ext_req = 1'b1;
    end
    for (int u = 0; u < n; u++) begin
      int k = 0;
      if (is_edge) begin
        idle_window(6, "R8");
        ext_req = 1'b1;
        repeat (2) @(negedge clk);
        ext_req = 1'b0;
      end
      @(negedge clk);
      while (!(bus_rd | bus_wr) && k < 60) begin @(negedge clk); k++; end
      chk(k < 60, rq, "unit never started", k, 0);
      for (int b = 0; b < beats; b++) begin
        if (b > 0) @(negedge clk);
        chk(bus_size == bsz, "R6", "bus size", bus_size, bsz);
        if (!single) begin
          chk(bus_rd && !bus_wr, "R3", "read cycle", {bus_rd, bus_wr}, 2'b10);
          chk(bus_addr == s, "R6", "source addr", bus_addr, s);
          chk(dack == !am, "R4", "dack in read", dack, !am);
          @(negedge clk);
          chk(bus_wr && !bus_rd, "R3", "write cycle", {bus_rd, bus_wr}, 2'b01);
          chk(bus_addr == d, "R6", "dest addr", bus_addr, d);
          chk(bus_wdata == dfun(s), "R3", "write data", bus_wdata, dfun(s));
          chk(dack == am, "R4", "dack in write", dack, am);
        end else begin
          chk(am ? (bus_wr && !bus_rd) : (bus_rd && !bus_wr), "R5", "single cycle type",
              {bus_rd, bus_wr}, am ? 2'b01 : 2'b10);
          chk(bus_addr == (am ? d : s), "R5", "single addr", bus_addr, am ? d : s);
          chk(dack == 1'b1, "R5", "single dack", dack, 1);
        end
        s += stp; d += stp;
      end
      if (u == n - 1) begin
        @(negedge clk);
        chk(done == 1'b1 && busy == 1'b0, "R7", "done/busy after last", {done, busy}, 2'b10);
        @(negedge clk);
        chk(done == 1'b0, "R7", "done pulse width", done, 0);
      end
    end
    ext_req = 1'b0; per_req = 1'b0;
  endtask

  task automatic do_xfer(input logic [7:0] c, input logic [31:0] s, input logic [31:0] d,
                         input logic [15:0] n);
    cfg_write(c, s, d, n, 1'b1);
    chk(!cfg_err, "R10", "legal config flagged", cfg_err, 0);
    chk(!addr_err, "R11", "aligned config flagged", addr_err, 0);
    run_check(c, s, d, n);
  endtask

  task automatic bad_cfg(input logic [7:0] c, input logic [31:0] s, input logic [31:0] d,
                         input logic [15:0] n, input bit is_addr);
    cfg_write(c, s, d, n, 1'b1);
    if (is_addr) chk(addr_err && !cfg_err, "R11", "addr error flag", {cfg_err, addr_err}, 2'b01);
    else         chk(cfg_err && !addr_err, "R10", "cfg error flag", {cfg_err, addr_err}, 2'b10);
    chk(!busy, is_addr ? "R11" : "R10", "started despite error", busy, 0);
    idle_window(5, is_addr ? "R11" : "R10");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(cfg_rb == 8'h00, "R1", "cfg after reset", cfg_rb, 0);
    chk({busy, done, cfg_err, addr_err} == 4'b0, "R1", "flags after reset",
        {busy, done, cfg_err, addr_err}, 0);

    do_xfer(8'h06, 32'h100, 32'h200, 3);   // R2 dual longword
    do_xfer(8'h0F, 32'h300, 32'h410, 2);   // R6 16-byte, mode 1
    do_xfer(8'h4B, 32'h500, 32'h620, 2);   // R8 single edge 16-byte
    do_xfer(8'h51, 32'h702, 32'h806, 2);   // R9 single level word
    do_xfer(8'h20, 32'h901, 32'hA03, 3);   // R9 peripheral byte
    do_xfer(8'h04, 32'h101, 32'h203, 2);   // R11 byte at odd address legal
    do_xfer(8'hC4, 32'h111, 32'h222, 2);   // R10 single + internal dst legal
    do_xfer(8'h07, 32'h110, 32'h220, 1);   // R11 16-aligned ok

    bad_cfg(8'h13, 32'h100, 32'h200, 2, 0); // R10 16-byte level
    bad_cfg(8'h23, 32'h100, 32'h200, 2, 0); // R10 16-byte peripheral
    bad_cfg(8'h84, 32'h100, 32'h200, 2, 0); // R10 dual byte internal dst
    bad_cfg(8'h04, 32'h100, 32'h200, 0, 0); // R10 zero count
    bad_cfg(8'h06, 32'h102, 32'h200, 2, 1); // R11 longword misaligned src
    bad_cfg(8'h07, 32'h100, 32'h208, 2, 1); // R11 16-byte dst on 8

    // R12 full standby mid-transfer
    cfg_write(8'h06, 32'h300, 32'h400, 8, 1'b1);
    repeat (3) @(negedge clk);
    stby = 1'b1;
    @(negedge clk);
    stby = 1'b0;
    chk(cfg_rb == 8'h00, "R12", "cfg after standby", cfg_rb, 0);
    chk(!busy, "R12", "busy after standby", busy, 0);
    idle_window(5, "R12");

    // R12 module standby holds
    mstby = 1'b1;
    cfg_write(8'h0E, 32'h600, 32'h700, 2, 1'b1);
    idle_window(8, "R12");
    chk(cfg_rb == 8'h0E, "R12", "cfg in module standby", cfg_rb, 8'h0E);
    chk(busy, "R12", "busy in module standby", busy, 1);
    mstby = 1'b0;
    run_check(8'h0E, 32'h600, 32'h700, 2);

    for (int i = 0; i < 25; i++) begin
      logic [1:0] sz = 2'($urandom % 4);
      int m = $urandom % 4;
      logic sg = 1'($urandom % 2), am = 1'($urandom % 2), di;
      logic [31:0] s, d, off_s, off_d;
      if (sz == 2'b11 && m >= 2) m = 1;
      di = (sg || sz != 2'b00) ? 1'($urandom % 2) : 1'b0;
      off_s = (sz == 2'b00) ? $urandom % 16 : (sz == 2'b01) ? ($urandom % 8) * 2 : 0;
      off_d = (sz == 2'b00) ? $urandom % 16 : (sz == 2'b01) ? ($urandom % 8) * 2 : 0;
      s = (($urandom % 4096) << 4) + off_s;
      d = (($urandom % 4096) << 4) + off_d;
      do_xfer({di, sg, m == 3, m == 2, am, m == 0, sz}, s, d, 16'(1 + $urandom % 3));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule